// File: doc/BRIEF.md
# Microcoded Control Sequencer for a Four-Instruction Accumulator Machine

This block is the control unit of a small accumulator processor that has four instructions. It holds a constant control store and a 5-bit control address register (CAR), which points at the control word being executed. It takes the two opcode bits of the instruction register as input. Each control word carries three things:

- the datapath enable bits;
- a return flag and four per-instruction dispatch flags;
- two next-address fields, one for sequential flow and one for a taken jump.

A small select circuit combines the flags with the decoded opcode. A 2-way multiplexer then picks one of the two next addresses, and CAR loads it on every clock. No step counter, phase register or CAR decoder is needed.

The block drives the enable vector of the current word and exposes CAR. The enable vector is read from the control store without a register, so both outputs change together, once per clock. The datapath registers and memory sit outside the block. The opcode input must stay stable while an instruction executes.

Each instruction follows the same route. Fetch runs at words 1 to 3. A dispatch chain at words 7 to 10 then tests the opcode one instruction per word. Control enters the instruction's routine, and the routine's last word returns to fetch.

Top module: `ucode_sequencer`

## Requirements
- R1: Reset is synchronous and active high. At every clock edge where `rst` is high, CAR loads 1, including in the middle of a routine. While CAR is 1 the enable vector is exactly bit 16.
- R2: Fetch is the same for every opcode: CAR steps 1, 2, 3, and then 7 on the next clock.
- R3: The enable vector has this bit layout. Bit 17 drives MAR onto the address bus. Bit 16 loads MAR from PC. Bit 15 loads PC from the ALU. Bit 14 loads MBR from the data bus. Bit 13 selects MBR as the adder operand. Bit 12 latches the ALU result. Bit 11 loads the accumulator from the ALU. Bit 10 loads the accumulator from MBR. Bit 9 loads MBR from the accumulator. Bit 8 drives MBR onto the data bus. Bit 7 loads PC from the address field of IR. Bit 6 selects PC as the adder operand. Bit 5 loads IR from MBR. Bit 4 loads MAR from the address field of IR. Bit 3 is carry-in. Bit 2 enables the adder. Bit 1 is memory read. Bit 0 is memory write. At word 2 the vector is exactly 18'h2404E.
- R4: Opcode 2'b00 (load) runs the route 7, 4, 5, 6. Word 4 asserts bit 4, word 5 asserts bits 17, 14 and 1, and word 6 asserts bit 10.
- R5: Opcode 2'b11 (store) runs the route 7, 8, 11, 12. Word 11 asserts bits 9 and 4, and word 12 asserts bits 17, 8 and 0.
- R6: Opcode 2'b01 (add) runs the route 7, 8, 9, 13, 14, 15, 16. Word 13 asserts bit 4, word 14 asserts bits 17, 14 and 1, word 15 asserts bits 13, 12 and 2, and word 16 asserts bit 11.
- R7: Opcode 2'b10 (jump) runs the route 7, 8, 9, 10, 17. Word 17 asserts bit 7.
- R8: The dispatch words 7 to 10 assert no enable bit.
- R9: Memory read (bit 1) and memory write (bit 0) are never high together. Whenever either of them is high, bit 17 is high.
- R10: One clock after CAR holds 6, 12, 16 or 17, CAR is 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; CAR updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; CAR loads 1 |
| opcode | input | 2 | IR bits 7:6: 00 load, 01 add, 10 jump, 11 store |
| car | output | 5 | Control address register: the word now executing |
| ctrl | output | 18 | Datapath enable vector of the current word, with the layout of R3 |

## Verification
The enable vector is a pure function of CAR. It is checked against the word CAR names in the same sample window. A new CAR value, whether it comes from the sequential field, a dispatch jump, a return to fetch or a reset, appears one rising edge after the cycle that chose it. The bench therefore drives and samples on falling edges. It drives the opcode only while CAR is 1. At each falling edge it compares both outputs with the next entry of its expected route, so a wrong word, a missing step or an extra step shows up at the cycle where it occurs. A reset in the middle of a routine is checked one edge after it is applied.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int AW     = 5;
    localparam int OPW    = 2;
    localparam int CTRL_W = 18;
    localparam int UDEPTH = 1 << AW;

    typedef logic [AW-1:0] uaddr_t;

    // Opcode encoding taken from IR bits 7:6
    typedef enum logic [OPW-1:0] {
        OP_LOAD  = 2'b00,
        OP_ADD   = 2'b01,
        OP_JUMP  = 2'b10,
        OP_STORE = 2'b11
    } opc_e;

    // Decoded opcode, exactly one bit high
    typedef struct packed {
        logic is_load;
        logic is_store;
        logic is_add;
        logic is_jump;
    } opsel_t;

    // Datapath enables, most significant field first (bit 17 .. bit 0)
    typedef struct packed {
        logic addr_drive;    // 17
        logic mar_from_pc;   // 16
        logic pc_from_alu;   // 15
        logic mbr_from_bus;  // 14
        logic opnd_mbr;      // 13
        logic alu_latch;     // 12
        logic acc_from_alu;  // 11
        logic acc_from_mbr;  // 10
        logic mbr_from_acc;  // 9
        logic mbr_to_bus;    // 8
        logic pc_from_ir;    // 7
        logic opnd_pc;       // 6
        logic ir_from_mbr;   // 5
        logic mar_from_ir;   // 4
        logic carry_in;      // 3
        logic add_en;        // 2
        logic mem_rd;        // 1
        logic mem_wr;        // 0
    } dp_ctrl_t;

    // Jump condition flags of a control word
    typedef struct packed {
        logic last;       // unconditional jump: end of a routine
        logic on_load;
        logic on_store;
        logic on_add;
        logic on_jump;
    } jflags_t;

    typedef struct packed {
        dp_ctrl_t ctl;
        jflags_t  jf;
        uaddr_t   seq_a;
        uaddr_t   jmp_a;
    } uword_t;

    // Control store map
    localparam uaddr_t UA_F1    = uaddr_t'(1);
    localparam uaddr_t UA_F2    = uaddr_t'(2);
    localparam uaddr_t UA_F3    = uaddr_t'(3);
    localparam uaddr_t UA_LD1   = uaddr_t'(4);
    localparam uaddr_t UA_LD2   = uaddr_t'(5);
    localparam uaddr_t UA_LD3   = uaddr_t'(6);
    localparam uaddr_t UA_DSP_L = uaddr_t'(7);
    localparam uaddr_t UA_DSP_S = uaddr_t'(8);
    localparam uaddr_t UA_DSP_A = uaddr_t'(9);
    localparam uaddr_t UA_DSP_J = uaddr_t'(10);
    localparam uaddr_t UA_ST1   = uaddr_t'(11);
    localparam uaddr_t UA_ST2   = uaddr_t'(12);
    localparam uaddr_t UA_AD1   = uaddr_t'(13);
    localparam uaddr_t UA_AD2   = uaddr_t'(14);
    localparam uaddr_t UA_AD3   = uaddr_t'(15);
    localparam uaddr_t UA_AD4   = uaddr_t'(16);
    localparam uaddr_t UA_JP1   = uaddr_t'(17);

    // Contents of one control store location. Unused locations fall back to fetch.
    function automatic uword_t uword_at(uaddr_t a);
        uword_t w;
        w = '0;
        case (a)
            UA_F1: begin
                w.ctl.mar_from_pc = 1'b1;
                w.seq_a = UA_F2;
            end
            UA_F2: begin
                w.ctl.addr_drive   = 1'b1;
                w.ctl.mbr_from_bus = 1'b1;
                w.ctl.opnd_pc      = 1'b1;
                w.ctl.add_en       = 1'b1;
                w.ctl.carry_in     = 1'b1;
                w.ctl.mem_rd       = 1'b1;
                w.seq_a = UA_F3;
            end
            UA_F3: begin
                w.ctl.pc_from_alu = 1'b1;
                w.ctl.ir_from_mbr = 1'b1;
                w.jf.last = 1'b1;
                w.jmp_a   = UA_DSP_L;
            end
            UA_LD1: begin
                w.ctl.mar_from_ir = 1'b1;
                w.seq_a = UA_LD2;
            end
            UA_LD2: begin
                w.ctl.addr_drive   = 1'b1;
                w.ctl.mbr_from_bus = 1'b1;
                w.ctl.mem_rd       = 1'b1;
                w.seq_a = UA_LD3;
            end
            UA_LD3: begin
                w.ctl.acc_from_mbr = 1'b1;
                w.jf.last = 1'b1;
                w.jmp_a   = UA_F1;
            end
            UA_DSP_L: begin
                w.jf.on_load = 1'b1;
                w.seq_a = UA_DSP_S;
                w.jmp_a = UA_LD1;
            end
            UA_DSP_S: begin
                w.jf.on_store = 1'b1;
                w.seq_a = UA_DSP_A;
                w.jmp_a = UA_ST1;
            end
            UA_DSP_A: begin
                w.jf.on_add = 1'b1;
                w.seq_a = UA_DSP_J;
                w.jmp_a = UA_AD1;
            end
            UA_DSP_J: begin
                w.jf.on_jump = 1'b1;
                w.seq_a = UA_DSP_L;
                w.jmp_a = UA_JP1;
            end
            UA_ST1: begin
                w.ctl.mbr_from_acc = 1'b1;
                w.ctl.mar_from_ir  = 1'b1;
                w.seq_a = UA_ST2;
            end
            UA_ST2: begin
                w.ctl.addr_drive = 1'b1;
                w.ctl.mbr_to_bus = 1'b1;
                w.ctl.mem_wr     = 1'b1;
                w.jf.last = 1'b1;
                w.jmp_a   = UA_F1;
            end
            UA_AD1: begin
                w.ctl.mar_from_ir = 1'b1;
                w.seq_a = UA_AD2;
            end
            UA_AD2: begin
                w.ctl.addr_drive   = 1'b1;
                w.ctl.mbr_from_bus = 1'b1;
                w.ctl.mem_rd       = 1'b1;
                w.seq_a = UA_AD3;
            end
            UA_AD3: begin
                w.ctl.opnd_mbr  = 1'b1;
                w.ctl.alu_latch = 1'b1;
                w.ctl.add_en    = 1'b1;
                w.seq_a = UA_AD4;
            end
            UA_AD4: begin
                w.ctl.acc_from_alu = 1'b1;
                w.jf.last = 1'b1;
                w.jmp_a   = UA_F1;
            end
            UA_JP1: begin
                w.ctl.pc_from_ir = 1'b1;
                w.jf.last = 1'b1;
                w.jmp_a   = UA_F1;
            end
            default: begin
                w.jf.last = 1'b1;
                w.jmp_a   = UA_F1;
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/useq_opdec.sv
module useq_opdec
    import useq_pkg::*;
#(
    parameter int OP_W = OPW
) (
    input  logic [OP_W-1:0] op,
    output opsel_t          sel
);
    localparam int NCODE = 1 << OP_W;

    logic [NCODE-1:0] hit;

    for (genvar k = 0; k < NCODE; k++) begin : g_dec
        assign hit[k] = (op == OP_W'(k));
    end

    always_comb begin
        sel.is_load  = hit[int'(OP_LOAD)];
        sel.is_store = hit[int'(OP_STORE)];
        sel.is_add   = hit[int'(OP_ADD)];
        sel.is_jump  = hit[int'(OP_JUMP)];
    end
endmodule

// File: rtl/useq_cstore.sv
module useq_cstore
    import useq_pkg::*;
#(
    parameter int DEPTH = UDEPTH
) (
    input  uaddr_t addr,
    output uword_t word
);
    uword_t tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign tbl[i] = uword_at(uaddr_t'(i));
    end

    assign word = tbl[addr];
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
    import useq_pkg::*;
(
    input  uword_t w,
    input  opsel_t dec,
    output uaddr_t nxt
);
    logic take;

    always_comb begin
        take = w.jf.last
             | (w.jf.on_load  & dec.is_load)
             | (w.jf.on_store & dec.is_store)
             | (w.jf.on_add   & dec.is_add)
             | (w.jf.on_jump  & dec.is_jump);
        nxt  = take ? w.jmp_a : w.seq_a;
    end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
    import useq_pkg::*;
#(
    parameter int     ADDR_W     = AW,
    parameter int     OP_W       = OPW,
    parameter int     CW         = CTRL_W,
    parameter uaddr_t RESET_ADDR = UA_F1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-1:0] car,
    output logic [CW-1:0]     ctrl
);
    uaddr_t car_q;
    uaddr_t car_d;
    uword_t cur_word;
    opsel_t dec;

    useq_opdec #(.OP_W(OP_W)) u_dec (
        .op  (opcode),
        .sel (dec)
    );

    useq_cstore #(.DEPTH(1 << ADDR_W)) u_store (
        .addr (car_q),
        .word (cur_word)
    );

    useq_nextaddr u_next (
        .w   (cur_word),
        .dec (dec),
        .nxt (car_d)
    );

    always_ff @(posedge clk) begin
        if (rst) car_q <= RESET_ADDR;
        else     car_q <= car_d;
    end

    assign car  = car_q;
    assign ctrl = cur_word.ctl;
endmodule

// File: rtl/ucode_sequencer_chk.sv
module ucode_sequencer_chk
    import useq_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [OPW-1:0] opcode,
    input logic [AW-1:0] car,
    input logic [CTRL_W-1:0] ctrl
);
    dp_ctrl_t c;
    assign c = dp_ctrl_t'(ctrl);

    p_reset_car_r1: assert property (@(posedge clk) rst |=> car == 5'd1);

    p_fetch_a_r2: assert property (@(posedge clk) disable iff (rst)
        car == 5'd1 |=> car == 5'd2);
    p_fetch_b_r2: assert property (@(posedge clk) disable iff (rst)
        car == 5'd2 |=> car == 5'd3);
    p_fetch_c_r2: assert property (@(posedge clk) disable iff (rst)
        car == 5'd3 |=> car == 5'd7);

    p_word2_r3: assert property (@(posedge clk) disable iff (rst)
        car == 5'd2 |-> ctrl == 18'h2404E);

    p_load_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (car == 5'd7 && opcode == 2'b00) |=> car == 5'd4);
    p_store_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (car == 5'd8 && opcode == 2'b11) |=> car == 5'd11);
    p_add_entry_r6: assert property (@(posedge clk) disable iff (rst)
        (car == 5'd9 && opcode == 2'b01) |=> car == 5'd13);
    p_jump_entry_r7: assert property (@(posedge clk) disable iff (rst)
        (car == 5'd10 && opcode == 2'b10) |=> car == 5'd17);

    p_dispatch_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (car >= 5'd7 && car <= 5'd10) |-> ctrl == '0);

    p_rdwr_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(c.mem_rd && c.mem_wr));
    p_rdwr_addr_r9: assert property (@(posedge clk) disable iff (rst)
        (c.mem_rd || c.mem_wr) |-> c.addr_drive);

    p_return_r10: assert property (@(posedge clk) disable iff (rst)
        (car == 5'd6 || car == 5'd12 || car == 5'd16 || car == 5'd17) |=> car == 5'd1);
endmodule

bind ucode_sequencer ucode_sequencer_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .car    (car),
    .ctrl   (ctrl)
);

// File: tb/sim_ucode_sequencer.sv
module sim_ucode_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    // Enable bit positions from R3
    localparam int B_ADRV = 17, B_MARPC = 16, B_PCALU = 15, B_MBRBUS = 14;
    localparam int B_OPMBR = 13, B_LATCH = 12, B_ACCALU = 11, B_ACCMBR = 10;
    localparam int B_MBRACC = 9, B_MBROUT = 8, B_PCIR = 7, B_OPPC = 6;
    localparam int B_IRMBR = 5, B_MARIR = 4, B_CIN = 3, B_ADD = 2, B_RD = 1, B_WR = 0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  opcode = 2'b00;
    logic [4:0]  car;
    logic [17:0] ctrl;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    ucode_sequencer u0 (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .car    (car),
        .ctrl   (ctrl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [17:0] bits(input int b0, input int b1 = -1, input int b2 = -1);
        logic [17:0] m = '0;
        if (b0 >= 0) m[b0] = 1'b1;
        if (b1 >= 0) m[b1] = 1'b1;
        if (b2 >= 0) m[b2] = 1'b1;
        return m;
    endfunction

    // Expected enables for each word, from R1 and R3..R8
    function automatic logic [17:0] exp_ctrl(input int a);
        case (a)
            1:  return bits(B_MARPC);
            2:  return bits(B_ADRV, B_MBRBUS, B_OPPC) | bits(B_ADD, B_CIN, B_RD);
            3:  return bits(B_PCALU, B_IRMBR);
            4:  return bits(B_MARIR);
            5:  return bits(B_ADRV, B_MBRBUS, B_RD);
            6:  return bits(B_ACCMBR);
            11: return bits(B_MBRACC, B_MARIR);
            12: return bits(B_ADRV, B_MBROUT, B_WR);
            13: return bits(B_MARIR);
            14: return bits(B_ADRV, B_MBRBUS, B_RD);
            15: return bits(B_OPMBR, B_LATCH, B_ADD);
            16: return bits(B_ACCALU);
            17: return bits(B_PCIR);
            default: return '0;
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic check_rdwr();
        check(!(ctrl[B_RD] && ctrl[B_WR]) && (!(ctrl[B_RD] || ctrl[B_WR]) || ctrl[B_ADRV]),
              "R9", "read/write exclusivity", int'(ctrl), int'(ctrl & bits(B_ADRV, B_RD, B_WR)));
    endtask

    // Walk one instruction; nsteps = 0 runs the whole route
    task automatic walk(input logic [1:0] op, input string rq, input int nsteps);
        int route[$];
        case (op)
            2'b00: route = '{1, 2, 3, 7, 4, 5, 6};
            2'b11: route = '{1, 2, 3, 7, 8, 11, 12};
            2'b01: route = '{1, 2, 3, 7, 8, 9, 13, 14, 15, 16};
            default: route = '{1, 2, 3, 7, 8, 9, 10, 17};
        endcase
        opcode = op;
        for (int i = 0; i < route.size(); i++) begin
            int a = route[i];
            string rq_a;
            string rq_c;
            if (nsteps != 0 && i >= nsteps) break;
            rq_a = (i < 3 || a == 7) ? "R2" : rq;
            rq_c = (a == 2) ? "R3" : ((a >= 7 && a <= 10) ? "R8" : rq);
            check(car == 5'(a), rq_a, "car", int'(car), a);
            check(ctrl == exp_ctrl(a), rq_c, "ctrl", int'(ctrl), int'(exp_ctrl(a)));
            check_rdwr();
            @(negedge clk);
        end
        if (nsteps == 0)
            check(car == 5'd1, "R10", "return to fetch", int'(car), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(car == 5'd1, "R1", "car in reset", int'(car), 1);
        check(ctrl == bits(B_MARPC), "R1", "ctrl in reset", int'(ctrl), int'(bits(B_MARPC)));
        rst = 1'b0;

        walk(2'b00, "R4", 0);
        walk(2'b11, "R5", 0);
        walk(2'b01, "R6", 0);
        walk(2'b10, "R7", 0);
        walk(2'b00, "R4", 0);

        // Reset during the add routine, with CAR at 14
        walk(2'b01, "R6", 7);
        check(car == 5'd14, "R6", "car before reset", int'(car), 14);
        rst = 1'b1;
        @(negedge clk);
        check(car == 5'd1, "R1", "car after mid-run reset", int'(car), 1);
        check(ctrl == bits(B_MARPC), "R1", "ctrl after mid-run reset", int'(ctrl), int'(bits(B_MARPC)));
        rst = 1'b0;

        walk(2'b11, "R5", 0);
        walk(2'b10, "R7", 0);
        walk(2'b01, "R6", 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule